// File: doc/BRIEF.md
# Ethernet receive destination address filter

This block watches the first six bytes of every received frame, which hold the destination address, and decides whether the frame is for this station. Four acceptance rules are available. An exact physical match compares the address with a programmed station address. A broadcast match accepts the all-ones address. A multicast hash match sends group addresses through a CRC-32 hash into one of 64 bins and accepts the frame when that bin is enabled in a programmable mask. A promiscuous enable accepts everything.

The receive datapath presents bytes with a valid strobe and marks the first byte of each frame with a start-of-frame strobe. The station address, the bin mask and the promiscuous enable are static configuration that is loaded at initialization. One clock after the last address byte, the block raises a decision-valid flag together with an accept bit and a code that names the rule that matched. The decision is held until the next frame starts.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, decision_valid_o, accept_o and match_o are all 0.
- R2: A byte is taken only in a cycle with byte_valid_i high. A taken byte with sof_i high is destination byte 0, and later taken bytes are bytes 1 to 5. Byte k is compared with station_addr_i[8k+7:8k].
- R3: decision_valid_o rises in the clock after the edge that takes byte 5 and stays low while bytes 0 to 4 arrive, with or without idle cycles between bytes.
- R4: Once valid, the decision (decision_valid_o, accept_o, match_o) holds. Bytes taken without sof_i do not change it.
- R5: When all six bytes equal the station address, the frame is accepted with match_o = 1 (physical).
- R6: The all-ones address FF:FF:FF:FF:FF:FF is accepted with match_o = 2 (broadcast), whatever the bin mask holds.
- R7: When bit 0 of byte 0 is set, the address is neither physical nor broadcast, and bin_mask_i[h] is 1, the frame is accepted with match_o = 3 (multicast). Here h is the hash bin. A CRC register starts at all ones and shifts in the 48 address bits, byte 0 first and each byte LSB first, using the polynomial 0x04C11DB7 with no final inversion. The six most significant bits of the register give h.
- R8: An address with bit 0 of byte 0 clear that is not the station address is rejected (match_o = 0, accept_o = 0) when promiscuous mode is off, whatever the bin mask holds.
- R9: With promisc_i high, every frame is accepted. match_o = 4 only when no other rule matches. Priority from highest to lowest is physical, broadcast, multicast, promiscuous.
- R10: A taken byte with sof_i high during bytes 1 to 5 abandons the partial address, and that byte becomes byte 0 of a new address.
- R11: A taken byte with sof_i high clears decision_valid_o, accept_o and match_o in the next clock. While decision_valid_o is low, accept_o and match_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Receive byte strobe |
| sof_i | input | 1 | First byte of frame, qualified by byte_valid_i |
| byte_i | input | 8 | Receive byte |
| station_addr_i | input | 48 | Station address; bits 7:0 are the first byte on the wire |
| bin_mask_i | input | 64 | Multicast hash bin enables |
| promisc_i | input | 1 | Accept all frames |
| decision_valid_o | output | 1 | Decision available for the current frame |
| accept_o | output | 1 | Frame accepted |
| match_o | output | 3 | 0 none, 1 physical, 2 broadcast, 3 multicast, 4 promiscuous |

## Verification
Several rules can match the same address in the single decision cycle, and the priority decides which code is reported. The bench provokes this by sending the broadcast address with every hash bin enabled and promiscuous mode on, and the station address with promiscuous mode on, and it expects the highest-ranked code. A second coincidence is a start-of-frame that arrives while an earlier decision is still held, or in the middle of an address. The bench checks that the old decision clears in the next cycle and that the new address is judged from its own first byte. A sweep of one-hot bin masks over all 64 bins checks that exactly the computed bin accepts a given group address.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;

  typedef enum logic [2:0] {
    M_NONE    = 3'd0,
    M_PHYS    = 3'd1,
    M_BCAST   = 3'd2,
    M_MCAST   = 3'd3,
    M_PROMISC = 3'd4
  } match_e;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // one byte of CRC-32, data LSB first, MSB-first register
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[31] ^ d[k];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_rxf_cmp.sv
module eth_rxf_cmp #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         first_i,
  input  logic         step_i,
  input  logic [W-1:0] byte_i,
  input  logic [W-1:0] ref_i,
  output logic         eq_o
);
  logic run_q;

  assign eq_o = (first_i | run_q) & (byte_i == ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= 1'b0;
    else if (first_i | step_i)  run_q <= eq_o;
  end

  // a mismatch sticks until a new frame starts (R5)
  assert_mismatch_sticks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !first_i) |=> !run_q);

  assert_no_eq_after_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !first_i && !run_q) |-> !eq_o);

endmodule

// File: rtl/eth_rxf_crc.sv
module eth_rxf_crc
  import eth_rxf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        first_i,
  input  logic        step_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_next_o
);
  logic [31:0] crc_q;

  assign crc_next_o = crc_byte(first_i ? 32'hFFFF_FFFF : crc_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               crc_q <= 32'hFFFF_FFFF;
    else if (first_i | step_i) crc_q <= crc_next_o;
  end

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int MASK_W    = 1 << HASH_W,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              sof_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic [MASK_W-1:0] bin_mask_i,
  input  logic              promisc_i,
  output logic              decision_valid_o,
  output logic              accept_o,
  output logic [2:0]        match_o
);
  logic             first, step, take, last;
  logic             active_q, mc_q, mc_now;
  logic [CNT_W-1:0] cnt_q, pos;
  logic [7:0]       node_byte;
  logic             phys_eq, bcast_eq;
  logic [31:0]      crc_next;
  logic [HASH_W-1:0] bin;
  match_e           match_d, match_q;
  logic             valid_q;

  assign first = byte_valid_i & sof_i;
  assign step  = byte_valid_i & ~sof_i & active_q;
  assign take  = first | step;
  assign pos   = first ? '0 : cnt_q;
  assign last  = take && (int'(pos) == ADDR_BYTES - 1);

  assign node_byte = station_addr_i[int'(pos)*8 +: 8];
  assign mc_now    = first ? byte_i[0] : mc_q;
  assign bin       = crc_next[31 -: HASH_W];

  eth_rxf_cmp #(.W(8)) u_phys (
    .clk_i, .rst_ni, .first_i(first), .step_i(step),
    .byte_i, .ref_i(node_byte), .eq_o(phys_eq)
  );

  eth_rxf_cmp #(.W(8)) u_bcast (
    .clk_i, .rst_ni, .first_i(first), .step_i(step),
    .byte_i, .ref_i(8'hFF), .eq_o(bcast_eq)
  );

  eth_rxf_crc u_crc (
    .clk_i, .rst_ni, .first_i(first), .step_i(step),
    .byte_i, .crc_next_o(crc_next)
  );

  always_comb begin
    if (phys_eq)                    match_d = M_PHYS;
    else if (bcast_eq)              match_d = M_BCAST;
    else if (mc_now && bin_mask_i[bin]) match_d = M_MCAST;
    else if (promisc_i)             match_d = M_PROMISC;
    else                            match_d = M_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mc_q     <= 1'b0;
      valid_q  <= 1'b0;
      match_q  <= M_NONE;
    end else begin
      if (take)  cnt_q <= pos + 1'b1;
      if (first) mc_q  <= byte_i[0];
      if (last) begin
        active_q <= 1'b0;
        valid_q  <= 1'b1;
        match_q  <= match_d;
      end else if (first) begin
        active_q <= 1'b1;
        valid_q  <= 1'b0;
        match_q  <= M_NONE;
      end
    end
  end

  assign decision_valid_o = valid_q;
  assign match_o          = match_q;
  assign accept_o         = (match_q != M_NONE);

  assert_rise_after_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(decision_valid_o) |-> $past(byte_valid_i));

  assert_hold_decision_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && !(sof_i && byte_valid_i)) |=>
      (decision_valid_o && $stable(match_o) && $stable(accept_o)));

  assert_sof_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ADDR_BYTES > 1) && sof_i && byte_valid_i) |=> (!decision_valid_o && !accept_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> (match_o == 3'd0));

  assert_code_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o <= 3'd4);

endmodule

// File: tb/eth_rx_addr_filter_bench.sv
module eth_rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0, sof = 1'b0, promisc = 1'b0;
  logic [7:0]  byte_d = 8'h00;
  logic [47:0] station = 48'h0A0B0C0D0E02;
  logic [63:0] mask = 64'h0;
  logic        dec_valid, accept;
  logic [2:0]  match;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;  // 50 MHz

  eth_rx_addr_filter u_eth_rx_addr_filter (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .sof_i(sof), .byte_i(byte_d),
    .station_addr_i(station), .bin_mask_i(mask), .promisc_i(promisc),
    .decision_valid_o(dec_valid), .accept_o(accept), .match_o(match)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // reflected-register form of the hash, bin bits reversed back
  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    logic fb;
    for (int i = 0; i < 48; i++) begin
      fb = r[0] ^ a[i];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic [2:0] ref_match(input logic [47:0] a, input logic [47:0] st,
                                           input logic [63:0] m, input logic p);
    if (a == st)                      return 3'd1;
    if (a == 48'hFFFF_FFFF_FFFF)      return 3'd2;
    if (a[0] && m[ref_bin(a)])        return 3'd3;
    if (p)                            return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  task automatic check(input string req, input logic ev, input logic [2:0] em);
    checks++;
    if (dec_valid !== ev || match !== em || accept !== (em != 3'd0)) begin
      fails++;
      $display("FAIL %s: valid=%0b match=%0d accept=%0b expected valid=%0b match=%0d accept=%0b",
               req, dec_valid, match, accept, ev, em, em != 3'd0);
    end
  endtask

  // called at a negedge, returns at the following negedge
  task automatic drive(input logic [7:0] b, input logic s);
    byte_d = b; sof = s; byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0; sof = 1'b0;
  endtask

  task automatic send(input logic [47:0] a, input bit gaps, input bit chk_early);
    for (int i = 0; i < 6; i++) begin
      if (chk_early && i == 5) check("R3 early", 1'b0, 3'd0);
      drive(a[8*i +: 8], i == 0);
      if (gaps && i < 5) begin byte_d = 8'h5A; sof = 1'b1; @(negedge clk); sof = 1'b0; end
    end
  endtask

  task automatic frame(input string req, input logic [47:0] a, input bit gaps);
    send(a, gaps, 1'b0);
    check(req, 1'b1, ref_match(a, station, mask, promisc));
  endtask

  initial begin
    logic [47:0] mc_a, rnd;
    logic [5:0]  hb;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R5: physical with idle gaps (sof without valid ignored)
    send(station, 1'b1, 1'b1);
    check("R5 physical gaps R2", 1'b1, 3'd1);
    send(station, 1'b0, 1'b1);
    check("R5 physical", 1'b1, 3'd1);
    frame("R8 last byte differs", station ^ 48'h0100_0000_0000, 1'b0);
    check("R8 expected reject", 1'b1, 3'd0);
    frame("R8 first byte differs", station ^ 48'h04, 1'b0);

    // R6: broadcast with empty mask
    mask = 64'h0;
    frame("R6 broadcast", 48'hFFFF_FFFF_FFFF, 1'b0);
    check("R6 broadcast code", 1'b1, 3'd2);

    // R7: one-hot sweep over all bins
    mc_a = 48'h0100_5E00_0001;
    hb   = ref_bin(mc_a);
    for (int i = 0; i < 64; i++) begin
      mask = 64'h1 << i;
      send(mc_a, 1'b0, 1'b0);
      check("R7 bin sweep", 1'b1, (i == int'(hb)) ? 3'd3 : 3'd0);
    end
    mask = ~(64'h1 << hb);
    frame("R7 only bin cleared", mc_a, 1'b0);

    // R8: unicast ignores mask
    mask = '1;
    frame("R8 unicast full mask", 48'h665544332210, 1'b0);
    check("R8 unicast code", 1'b1, 3'd0);

    // R9: promiscuous and priority
    promisc = 1'b1;
    frame("R9 promisc unicast", 48'h665544332210, 1'b0);
    check("R9 promisc code", 1'b1, 3'd4);
    frame("R9 bcast over hash", 48'hFFFF_FFFF_FFFF, 1'b0);
    check("R9 bcast priority", 1'b1, 3'd2);
    frame("R9 phys priority", station, 1'b0);
    check("R9 phys code", 1'b1, 3'd1);
    promisc = 1'b0; mask = '0;

    // R4: trailing bytes do not disturb decision
    send(station, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) drive(8'hFF, 1'b0);
    check("R4 hold", 1'b1, 3'd1);

    // R11 clear on sof, R10 restart mid-address
    drive(8'h02, 1'b1);
    check("R11 sof clears", 1'b0, 3'd0);
    drive(8'h0E, 1'b0);
    drive(8'h0D, 1'b0);
    send(48'hFFFF_FFFF_FFFF, 1'b0, 1'b1);
    check("R10 restart", 1'b1, 3'd2);

    // mixed sweep
    for (int n = 0; n < 200; n++) begin
      seed = xs(seed); rnd[31:0] = seed;
      seed = xs(seed); rnd[47:32] = seed[15:0];
      seed = xs(seed); mask[31:0] = seed;
      seed = xs(seed); mask[63:32] = seed;
      promisc = seed[7] & seed[3];
      if (n % 17 == 0) rnd = station;
      if (n % 23 == 0) rnd = 48'hFFFF_FFFF_FFFF;
      send(rnd, seed[11], 1'b0);
      check("R7 R9 mixed", 1'b1, ref_match(rnd, station, mask, promisc));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule